// File: doc/BRIEF.md
# Clocked Byte-Wide Asynchronous SRAM Emulator

This block models a byte-wide static memory whose control pins behave like an asynchronous part, but it runs entirely on a fast system clock. The chip-select, output-enable and write-strobe pins are active low and are sampled on every rising clock edge. From them the block decodes the read, write and deselect modes and frames each write the way a real asynchronous memory does. The shared data bus is split into an input byte, an output byte, a drive enable and a data-valid flag. Access and hold times are counted in clock cycles, each set by a parameter. The storage array is small and sized by a parameter, and only the low address bits index it.

A power-fail controller drives the inhibit input. While inhibit is asserted the memory acts as deselected and discards any write that has not yet committed. A write whose address moves inside its window is refused and flagged.

Top module: `sram_emu`

## Requirements
- R1: Reset clears doutEn, doutValid and addrViolation. doutEn is high in the cycle after a sampled edge with ceN=0, oeN=0, inhibit=0 and weN=1. It stays low after any edge where ceN=1 or oeN=1.
- R2: In read mode, doutValid rises, with dout holding the byte at the current address, at the first edge where three conditions hold together. The address has been unchanged for ADDR_ACC_CYC edges since its last change. ceN has been low for CE_ACC_CYC edges since its fall. oeN has been low for OE_ACC_CYC edges since its fall. Each edge where the signal changes or falls counts as 0.
- R3: A write ends at the first edge where weN or ceN is sampled high. The din value sampled at that edge is stored at the window's address. A read of that address from the same edge onward returns it.
- R4: A write window opens at the first edge where both weN and ceN are sampled low, whichever of the two fell last. The address sampled at that edge is the write target.
- R5: If ceN and weN fall on the same edge, doutEn stays low for the whole write, whatever oeN does.
- R6: If weN falls while the outputs are driven, doutEn stays high for WE_OFF_CYC edges counted from the fall, with the falling edge counted as 0. It goes low at the edge whose count equals WE_OFF_CYC.
- R7: A valid read survives an address change for ADDR_HOLD_CYC edges, counting the change edge as 0, with dout unchanged. doutValid then stays low until the R2 access time is met for the new address.
- R8: While inhibit is sampled high, doutEn and doutValid go low and every other input is ignored. An open write window closes without storing. After release, strobes that are still low count as fresh falls.
- R9: If the address sampled inside an open window, or at its closing edge, differs from the opening address, addrViolation goes high and nothing is stored. The flag stays high until the next window opens.
- R10: The array holds 2**IDX_W bytes, indexed by addr[IDX_W-1:0]. Addresses that differ only in the higher bits alias to the same byte. All bytes read as zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every pin is sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write strobe, active low |
| inhibit | input | 1 | Forces deselect, driven by a power-fail controller |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus |
| doutEn | output | 1 | Bus drive enable |
| doutValid | output | 1 | dout holds settled data for the current address |
| addrViolation | output | 1 | The last write window saw its address move |

## Verification
Every output is registered, so a stimulus applied at one edge shows up at the ports just after that edge. Apart from that one register, only the delays are counted in edges. doutValid rises at the edge where the slowest of the address, chip-select and output-enable counts reaches its parameter. doutEn falls exactly WE_OFF_CYC edges after the write strobe falls. A committed byte can be read back at the very edge that ends the write. The bench drives inputs on falling edges and keeps a behavioural model that it advances on each rising edge. It compares the model with all outputs at the following falling edge, and adds directed checks at the cycle counts worked out above.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  // Strobes passed from the control FSM to the datapath each cycle.
  typedef struct packed {
    logic openWin;    // capture the write target address
    logic commit;     // store din at the captured address
    logic loadRead;   // refresh dout from the array
    logic enNext;     // next value of the drive enable
    logic validNext;  // next value of the valid flag
  } memStrobe_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
  import sram_emu_pkg::*;
#(
  parameter int ADDR_ACC_CYC  = 4,
  parameter int CE_ACC_CYC    = 3,
  parameter int OE_ACC_CYC    = 2,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int WE_OFF_CYC    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       inhibit,
  input  logic       addrChanged,
  input  logic       winAddrMatch,
  input  logic       doutEn,
  input  logic       doutValid,
  output memStrobe_t strobe,
  output logic       addrViolation
);

  localparam int AGE_MAX = maxOf4(ADDR_ACC_CYC, CE_ACC_CYC, OE_ACC_CYC, WE_OFF_CYC);
  localparam int AGE_W   = $clog2(AGE_MAX + 1) + 1;
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_MAX);
  localparam int N_STROBE = 3;  // 0: chip select, 1: output enable, 2: write

  logic [N_STROBE-1:0] levelAct;
  logic [N_STROBE-1:0] prevAct;
  logic [AGE_W-1:0]    age     [N_STROBE];
  logic [AGE_W-1:0]    ageNext [N_STROBE];
  logic [AGE_W-1:0]    addrAge;
  logic [AGE_W-1:0]    addrAgeNext;
  logic                winOpen;
  logic                weAct;
  logic                rdMode;
  logic                timingOk;
  logic                freshRead;
  logic                holdRead;

  assign levelAct = {~weN & ~inhibit, ~oeN & ~inhibit, ~ceN & ~inhibit};

  function automatic logic [AGE_W-1:0] satInc(input logic [AGE_W-1:0] v);
    return (v >= AGE_TOP) ? AGE_TOP : v + 1'b1;
  endfunction

  // One age counter per strobe: cycles since the strobe went active.
  for (genvar gi = 0; gi < N_STROBE; gi++) begin : g_age
    always_comb begin
      if (!levelAct[gi])     ageNext[gi] = '0;
      else if (!prevAct[gi]) ageNext[gi] = '0;
      else                   ageNext[gi] = satInc(age[gi]);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        age[gi]     <= '0;
        prevAct[gi] <= 1'b0;
      end else begin
        age[gi]     <= ageNext[gi];
        prevAct[gi] <= levelAct[gi];
      end
    end
  end

  assign addrAgeNext = addrChanged ? '0 : satInc(addrAge);

  always_ff @(posedge clk) begin
    if (!rstN) addrAge <= '0;
    else       addrAge <= addrAgeNext;
  end

  // Write window framing.
  assign weAct = levelAct[0] & levelAct[2];

  always_comb begin
    strobe.openWin = ~winOpen & weAct;
    strobe.commit  = winOpen & ~weAct & ~inhibit & winAddrMatch & ~addrViolation;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winOpen       <= 1'b0;
      addrViolation <= 1'b0;
    end else begin
      if (!winOpen) begin
        if (weAct) begin
          winOpen       <= 1'b1;
          addrViolation <= 1'b0;
        end
      end else begin
        if (!inhibit && !winAddrMatch) addrViolation <= 1'b1;
        if (!weAct) winOpen <= 1'b0;
      end
    end
  end

  // Output drive and read timing.
  assign rdMode   = levelAct[0] & ~levelAct[2];
  assign timingOk = (ageNext[0] >= AGE_W'(CE_ACC_CYC)) && (ageNext[1] >= AGE_W'(OE_ACC_CYC));

  always_comb begin
    strobe.enNext = levelAct[0] & levelAct[1] &
                    (~levelAct[2] | (doutEn & (ageNext[2] < AGE_W'(WE_OFF_CYC))));
    freshRead = strobe.enNext & rdMode & timingOk &
                (addrAgeNext >= AGE_W'(ADDR_ACC_CYC));
    holdRead  = strobe.enNext & rdMode & timingOk & doutValid &
                (addrAgeNext < AGE_W'(ADDR_HOLD_CYC));
    strobe.loadRead  = freshRead;
    strobe.validNext = freshRead | holdRead;
  end

  AST_SAME_FALL_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !weN && $past(ceN) && $past(weN)) |=> !doutEn);  // R5

  AST_WE_FALL_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (doutEn && $past(weN) && !weN && !ceN && !oeN && !inhibit && (WE_OFF_CYC > 0)) |=> doutEn);  // R6

endmodule

// File: rtl/sram_emu_datapath.sv
module sram_emu_datapath
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              inhibit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  memStrobe_t        strobe,
  output logic              addrChanged,
  output logic              winAddrMatch,
  output logic [DATA_W-1:0] dout,
  output logic              doutEn,
  output logic              doutValid
);

  localparam int DEPTH = 2 ** IDX_W;

  logic [ADDR_W-1:0] lastAddr;
  logic [ADDR_W-1:0] winAddr;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  rdIdx;
  logic [IDX_W-1:0]  wrIdx;
  logic [DATA_W-1:0] readByte;

  assign addrChanged  = (addr != lastAddr);
  assign winAddrMatch = (addr == winAddr);
  assign rdIdx        = addr[IDX_W-1:0];
  assign wrIdx        = winAddr[IDX_W-1:0];
  assign readByte     = (strobe.commit && (wrIdx == rdIdx)) ? din : mem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
      winAddr  <= '0;
    end else begin
      lastAddr <= addr;
      if (strobe.openWin) winAddr <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.commit) begin
      mem[wrIdx] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dout      <= '0;
      doutEn    <= 1'b0;
      doutValid <= 1'b0;
    end else begin
      if (strobe.loadRead) dout <= readByte;
      doutEn    <= strobe.enNext;
      doutValid <= strobe.validNext;
    end
  end

  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(inhibit) |-> (!doutEn && !doutValid));  // R8

  AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    doutValid |-> doutEn);  // R2

  AST_COMMIT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> ($past(!ceN && !weN) && (ceN || weN)));  // R3

  AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    doutEn |-> !$past(inhibit));  // R1

endmodule

// File: rtl/sram_emu.sv
module sram_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int IDX_W         = 6,
  parameter int ADDR_ACC_CYC  = 4,
  parameter int CE_ACC_CYC    = 3,
  parameter int OE_ACC_CYC    = 2,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int WE_OFF_CYC    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              inhibit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              doutEn,
  output logic              doutValid,
  output logic              addrViolation
);

  memStrobe_t strobe;
  logic       addrChanged;
  logic       winAddrMatch;

  sram_emu_ctrl #(
    .ADDR_ACC_CYC (ADDR_ACC_CYC),
    .CE_ACC_CYC   (CE_ACC_CYC),
    .OE_ACC_CYC   (OE_ACC_CYC),
    .ADDR_HOLD_CYC(ADDR_HOLD_CYC),
    .WE_OFF_CYC   (WE_OFF_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ceN          (ceN),
    .oeN          (oeN),
    .weN          (weN),
    .inhibit      (inhibit),
    .addrChanged  (addrChanged),
    .winAddrMatch (winAddrMatch),
    .doutEn       (doutEn),
    .doutValid    (doutValid),
    .strobe       (strobe),
    .addrViolation(addrViolation)
  );

  sram_emu_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ceN         (ceN),
    .weN         (weN),
    .inhibit     (inhibit),
    .addr        (addr),
    .din         (din),
    .strobe      (strobe),
    .addrChanged (addrChanged),
    .winAddrMatch(winAddrMatch),
    .dout        (dout),
    .doutEn      (doutEn),
    .doutValid   (doutValid)
  );

endmodule

// File: tb/sram_emu_bench.sv
module sram_emu_bench;

  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 6;
  localparam int DEPTH  = 2 ** IDX_W;
  localparam int T_ADDR = 4;
  localparam int T_CE   = 3;
  localparam int T_OE   = 2;
  localparam int T_HOLD = 1;
  localparam int T_WOFF = 2;
  localparam int SAT    = 4;
  localparam int WATCHDOG_CYC = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, inhibit = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic doutEn, doutValid, addrViolation;

  always #5 clk = ~clk;

  sram_emu #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .ADDR_ACC_CYC(T_ADDR), .CE_ACC_CYC(T_CE), .OE_ACC_CYC(T_OE),
    .ADDR_HOLD_CYC(T_HOLD), .WE_OFF_CYC(T_WOFF)
  ) u_sram_emu (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .inhibit(inhibit),
    .addr(addr), .din(din), .dout(dout), .doutEn(doutEn), .doutValid(doutValid),
    .addrViolation(addrViolation)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string curReq = "R1";

  // Behavioural reference model.
  logic [7:0] mMem [DEPTH];
  int mAddrAge, mCeAge, mOeAge, mWeAge;
  bit mPrevCe, mPrevOe, mPrevWe;
  int unsigned mLast, mWinAddr;
  bit mWin, mViol, mEn, mValid;
  logic [7:0] mDout;

  function automatic int bump(input int v);
    return (v >= SAT) ? SAT : v + 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 8'h00;
      mAddrAge = 0; mCeAge = 0; mOeAge = 0; mWeAge = 0;
      mPrevCe = 0; mPrevOe = 0; mPrevWe = 0;
      mLast = 0; mWinAddr = 0; mWin = 0; mViol = 0; mEn = 0; mValid = 0; mDout = 0;
    end else begin
      bit ce, oe, we, act, enN, rd, tOk, fresh, hold;
      ce = !ceN && !inhibit;
      oe = !oeN && !inhibit;
      we = !weN && !inhibit;
      mAddrAge = (addr != mLast) ? 0 : bump(mAddrAge);
      mLast = addr;
      mCeAge = ce ? (mPrevCe ? bump(mCeAge) : 0) : 0;
      mOeAge = oe ? (mPrevOe ? bump(mOeAge) : 0) : 0;
      mWeAge = we ? (mPrevWe ? bump(mWeAge) : 0) : 0;
      mPrevCe = ce; mPrevOe = oe; mPrevWe = we;
      act = ce && we;
      if (mWin) begin
        if (!act && !inhibit && !mViol && addr == mWinAddr)
          mMem[mWinAddr % DEPTH] = din;
        if (!inhibit && addr != mWinAddr) mViol = 1;
        if (!act) mWin = 0;
      end else if (act) begin
        mWin = 1; mWinAddr = addr; mViol = 0;
      end
      enN = ce && oe && (!we || (mEn && mWeAge < T_WOFF));
      rd  = ce && !we;
      tOk = (mCeAge >= T_CE) && (mOeAge >= T_OE);
      fresh = enN && rd && tOk && (mAddrAge >= T_ADDR);
      hold  = enN && rd && tOk && mValid && (mAddrAge < T_HOLD);
      if (fresh) mDout = mMem[addr % DEPTH];
      mValid = fresh || hold;
      mEn = enN;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison with the model, away from the rising edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(doutEn == mEn, curReq, "doutEn", doutEn, mEn);
      check(doutValid == mValid, curReq, "doutValid", doutValid, mValid);
      check(addrViolation == mViol, curReq, "addrViolation", addrViolation, mViol);
      if (mValid) check(dout == mDout, curReq, "dout", dout, mDout);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", "run did not finish", 0, 1);
      finishRun();
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    check(!doutEn && !doutValid && !addrViolation, "R1", "reset outputs",
          {doutEn, doutValid, addrViolation}, 0);

    // R4 write framed by the write strobe (chip select first).
    curReq = "R4";
    addr = 5; ceN = 0; step(2);
    weN = 0; din = 8'hAA; step(3);
    weN = 1; step(1);
    ceN = 1; step(1);

    // R4 write framed by chip select (write strobe first).
    weN = 0; addr = 9; din = 8'h55; step(2);
    ceN = 0; step(3);
    ceN = 1; step(1);
    weN = 1; step(1);

    // R2 read with access timing.
    curReq = "R2";
    addr = 5; ceN = 0; oeN = 0; step(3);
    check(!doutValid, "R2", "valid before access time", doutValid, 0);
    step(5);
    check(doutValid && dout == 8'hAA, "R2", "read byte", dout, 8'hAA);

    // R7 address hold, then re-access.
    curReq = "R7";
    addr = 9; step(1);
    check(doutValid && dout == 8'hAA, "R7", "held old data", dout, 8'hAA);
    step(1);
    check(!doutValid, "R7", "indeterminate after hold", doutValid, 0);
    step(3);
    check(doutValid && dout == 8'h55, "R7", "new byte after access", dout, 8'h55);

    // R6 write strobe turns off the driven bus; R3 commit with same-edge read.
    curReq = "R6";
    weN = 0; din = 8'h33; step(1);
    check(doutEn, "R6", "still driving at fall", doutEn, 1);
    step(2);
    check(!doutEn, "R6", "drive off after delay", doutEn, 0);
    step(2);
    curReq = "R3";
    weN = 1; step(1);
    check(doutValid && dout == 8'h33, "R3", "committed byte read back", dout, 8'h33);
    ceN = 1; oeN = 1; step(2);

    // R5 chip select and write strobe fall together.
    curReq = "R5";
    oeN = 0; step(1);
    addr = 30; din = 8'h11; ceN = 0; weN = 0; step(4);
    check(!doutEn, "R5", "bus stays undriven", doutEn, 0);
    weN = 1; ceN = 1; oeN = 1; step(2);

    // R9 address moves inside a write window.
    curReq = "R9";
    addr = 12; din = 8'h77; ceN = 0; weN = 0; step(2);
    addr = 13; step(1);
    check(addrViolation, "R9", "violation flagged", addrViolation, 1);
    weN = 1; ceN = 1; step(2);
    check(addrViolation, "R9", "violation sticky", addrViolation, 1);
    addr = 12; ceN = 0; oeN = 0; step(8);
    check(doutValid && dout == 8'h00, "R9", "byte 12 untouched", dout, 0);
    addr = 13; step(8);
    check(doutValid && dout == 8'h00, "R9", "byte 13 untouched", dout, 0);

    // R8 inhibit during a read, then during a write.
    curReq = "R8";
    inhibit = 1; step(1);
    check(!doutEn && !doutValid, "R8", "inhibit deselects read", {doutEn, doutValid}, 0);
    inhibit = 0; ceN = 1; oeN = 1; step(2);
    addr = 20; din = 8'h99; ceN = 0; weN = 0; step(2);
    inhibit = 1; step(2);
    check(!doutEn, "R8", "no drive while inhibited", doutEn, 0);
    ceN = 1; weN = 1; step(1);
    inhibit = 0; step(2);
    ceN = 0; oeN = 0; step(8);
    check(doutValid && dout == 8'h00, "R8", "abandoned write not stored", dout, 0);
    ceN = 1; oeN = 1; step(2);

    // R10 aliasing of high address bits.
    curReq = "R10";
    addr = 67; din = 8'hC3; ceN = 0; weN = 0; step(1);
    check(!addrViolation, "R10", "new window clears flag", addrViolation, 0);
    step(2);
    weN = 1; ceN = 1; step(1);
    addr = 3; ceN = 0; oeN = 0; step(8);
    check(doutValid && dout == 8'hC3, "R10", "aliased byte", dout, 8'hC3);
    ceN = 1; oeN = 1; step(2);
    check(!doutEn && !doutValid, "R1", "deselect drops drive", {doutEn, doutValid}, 0);

    finishRun();
  end

endmodule